// File: doc/BRIEF.md
# Data-Dependent Fail-First Vector Compare Unit

This unit steps through a vector of up to VL elements, one per clock. For each element it reads one entry of an external integer register file and compares it, as a signed number, with a sign-extended 16-bit immediate. The result is written out as a 3-bit condition field to a separate condition store. The source read address and the condition write address each start at a base number. Each one moves forward by one per element only when its operand is flagged as a vector. Otherwise it stays on the base entry.

Every condition produced is also tested. The test picks one of the three condition bits and an expected polarity; selector value 3 turns the test off. The first element whose test fails ends the loop early, and the vector length is rewritten from the data. In inclusive mode the new length counts the failing element and its condition is written. In exclusive mode the new length stops just before it and its condition is dropped. The result may be zero. If no element fails, the full VL is processed and returned unchanged.

The register file sits outside the block: the unit drives a read address and expects the addressed data back in the same cycle.

Top module: `ddff_cmp_unit`

## Requirements
- R1: While reset is high and after it is released, busy, done and cw_en are 0 and vl_out is 0; a reset during a run abandons it.
- R2: cw_val is {lt, gt, eq} (bit 2 = less, bit 1 = greater, bit 0 = equal), from a signed compare of the 64-bit read data with the immediate sign-extended from 16 bits; exactly one bit is set.
- R3: For element i, rd_addr is src_base + i modulo the register count when src_vec is 1, and src_base for every element when src_vec is 0.
- R4: For element i, cw_addr is dst_base + i modulo the condition store size when dst_vec is 1, and dst_base for every element when dst_vec is 0.
- R5: test_sel 0, 1, 2 selects the less, greater or equal bit; the test fails when that bit differs from test_pol; test_sel 3 never fails.
- R6: Inclusive mode (incl_mode = 1): a failure at element i writes element i, returns vl_out = i + 1 and writes nothing after it.
- R7: Exclusive mode (incl_mode = 0): a failure at element i writes no condition for element i, returns vl_out = i and writes nothing after it.
- R8: If no element fails, exactly VL conditions are written and vl_out equals VL.
- R9: A start with VL = 0 writes nothing and gives done one cycle later with vl_out = 0.
- R10: A failure at element 0 in exclusive mode gives vl_out = 0 and no writes.
- R11: done is a one-cycle pulse that is never high while busy; a start while busy is ignored.
- R12: The start is sampled at one clock edge; element k's write appears after edge k+1, one element per cycle, and done appears together with the write of the last processed element.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a loop; sampled only while idle |
| src_base | input | REG_AW | First register file entry read |
| src_vec | input | 1 | Source is a vector (address advances per element) |
| dst_base | input | CR_AW | First condition field written |
| dst_vec | input | 1 | Destination is a vector (address advances per element) |
| imm | input | 16 | Signed immediate compared against each element |
| vl_in | input | VL_W | Requested vector length |
| test_sel | input | 2 | 0 less, 1 greater, 2 equal, 3 no test |
| test_pol | input | 1 | Expected value of the tested bit |
| incl_mode | input | 1 | 1 inclusive, 0 exclusive truncation |
| rd_addr | output | REG_AW | Register file read address |
| rd_data | input | XLEN | Register file read data, same cycle |
| busy | output | 1 | Loop in progress |
| cw_en | output | 1 | Condition write strobe |
| cw_addr | output | CR_AW | Condition write address |
| cw_val | output | 3 | Condition value {lt, gt, eq} |
| done | output | 1 | One-cycle end-of-loop pulse |
| vl_out | output | VL_W | Resulting vector length |

## Verification
Two things can end a loop in the same cycle: the element count running out and a failed test. Cases make the test fail on element VL-1 in both inclusive and exclusive modes. The bench then checks that a single done pulse arrives in the cycle of that element. It also checks that vl_out is VL in inclusive mode and VL-1 in exclusive mode, and that the final condition write is present or absent to match.

// File: rtl/ddff_pkg.sv
package ddff_pkg;

    localparam int IMM_W  = 16;
    localparam int COND_W = 3;

    // condition field: bit 2 less, bit 1 greater, bit 0 equal
    typedef struct packed {
        logic lt;
        logic gt;
        logic eq;
    } cond_t;

    typedef enum logic [1:0] {
        TS_LT   = 2'd0,
        TS_GT   = 2'd1,
        TS_EQ   = 2'd2,
        TS_NONE = 2'd3
    } test_sel_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } state_e;

    function automatic logic pick_bit(cond_t c, test_sel_e s);
        case (s)
            TS_LT:   return c.lt;
            TS_GT:   return c.gt;
            default: return c.eq;
        endcase
    endfunction

endpackage

// File: rtl/ddff_cmp.sv
module ddff_cmp
    import ddff_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0]  opnd,
    input  logic [IMM_W-1:0] imm,
    output cond_t            cond
);
    localparam int EXT_W = XLEN - IMM_W;

    logic signed [XLEN-1:0] a_s;
    logic signed [XLEN-1:0] b_s;

    always_comb begin
        a_s     = opnd;
        b_s     = {{EXT_W{imm[IMM_W-1]}}, imm};
        cond.lt = (a_s < b_s);
        cond.gt = (a_s > b_s);
        cond.eq = (a_s == b_s);
    end
endmodule

// File: rtl/ddff_test.sv
module ddff_test
    import ddff_pkg::*;
(
    input  cond_t     cond,
    input  test_sel_e sel,
    input  logic      pol,
    output logic      fail
);
    always_comb begin
        if (sel == TS_NONE) fail = 1'b0;
        else                fail = (pick_bit(cond, sel) != pol);
    end
endmodule

// File: rtl/ddff_index.sv
module ddff_index #(
    parameter int AW = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] base,
    input  logic          vec,
    input  logic          adv,
    output logic [AW-1:0] addr
);
    logic [AW-1:0] base_q;
    logic [AW-1:0] off;
    logic          vec_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            off    <= '0;
            vec_q  <= 1'b0;
        end else if (load) begin
            base_q <= base;
            off    <= '0;
            vec_q  <= vec;
        end else if (adv && vec_q) begin
            off <= off + 1'b1;
        end
    end

    assign addr = base_q + off;

    // R3 / R4: a scalar operand stays put, a vector operand steps by one
    assert_scalar_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (adv && !vec_q && !load) |=> $stable(addr));
    assert_vector_step_R4: assert property (@(posedge clk) disable iff (rst)
        (adv && vec_q && !load) |=> (addr == $past(addr) + 1'b1));
endmodule

// File: rtl/ddff_ctrl.sv
module ddff_ctrl
    import ddff_pkg::*;
#(
    parameter int VL_W  = 7,
    parameter int CR_AW = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [VL_W-1:0]  vl_in,
    input  logic             incl_mode,
    input  logic [1:0]       test_sel,
    input  logic             test_pol,
    input  logic [IMM_W-1:0] imm,
    input  cond_t            cond,
    input  logic             fail,
    input  logic [CR_AW-1:0] dst_addr,
    output logic             busy,
    output logic             load,
    output logic             adv,
    output test_sel_e        sel_q,
    output logic             pol_q,
    output logic [IMM_W-1:0] imm_q,
    output logic             cw_en,
    output logic [CR_AW-1:0] cw_addr,
    output cond_t            cw_val,
    output logic             done,
    output logic [VL_W-1:0]  vl_out
);
    state_e          state;
    logic [VL_W-1:0] idx;
    logic [VL_W-1:0] vl_q;
    logic            incl_q;
    logic            last;

    assign busy = (state == ST_RUN);
    assign load = (state == ST_IDLE) && start;
    assign last = (idx == VL_W'(vl_q - 1'b1));
    assign adv  = busy && !fail && !last;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            idx     <= '0;
            vl_q    <= '0;
            incl_q  <= 1'b0;
            sel_q   <= TS_NONE;
            pol_q   <= 1'b0;
            imm_q   <= '0;
            cw_en   <= 1'b0;
            cw_addr <= '0;
            cw_val  <= '0;
            done    <= 1'b0;
            vl_out  <= '0;
        end else begin
            cw_en <= 1'b0;
            done  <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        vl_q   <= vl_in;
                        incl_q <= incl_mode;
                        sel_q  <= test_sel_e'(test_sel);
                        pol_q  <= test_pol;
                        imm_q  <= imm;
                        idx    <= '0;
                        if (vl_in == '0) begin
                            done   <= 1'b1;
                            vl_out <= '0;
                        end else begin
                            state <= ST_RUN;
                        end
                    end
                end
                default: begin
                    if (!(fail && !incl_q)) begin
                        cw_en   <= 1'b1;
                        cw_addr <= dst_addr;
                        cw_val  <= cond;
                    end
                    if (fail) begin
                        vl_out <= incl_q ? VL_W'(idx + 1'b1) : idx;
                        done   <= 1'b1;
                        state  <= ST_IDLE;
                    end else if (last) begin
                        vl_out <= vl_q;
                        done   <= 1'b1;
                        state  <= ST_IDLE;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
            endcase
        end
    end

    assert_excl_drop_R7: assert property (@(posedge clk) disable iff (rst)
        (busy && fail && !incl_q) |=> !cw_en);
    assert_done_idle_R11: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
    assert_write_follows_run_R12: assert property (@(posedge clk) disable iff (rst)
        cw_en |-> $past(busy));
    assert_vl_bound_R6: assert property (@(posedge clk) disable iff (rst)
        done |-> (vl_out <= vl_q));
endmodule

// File: rtl/ddff_cmp_unit.sv
module ddff_cmp_unit
    import ddff_pkg::*;
#(
    parameter int XLEN   = 64,
    parameter int REG_AW = 7,
    parameter int CR_AW  = 6,
    parameter int MAXVL  = 64,
    parameter int VL_W   = $clog2(MAXVL + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [REG_AW-1:0] src_base,
    input  logic              src_vec,
    input  logic [CR_AW-1:0]  dst_base,
    input  logic              dst_vec,
    input  logic [15:0]       imm,
    input  logic [VL_W-1:0]   vl_in,
    input  logic [1:0]        test_sel,
    input  logic              test_pol,
    input  logic              incl_mode,
    output logic [REG_AW-1:0] rd_addr,
    input  logic [XLEN-1:0]   rd_data,
    output logic              busy,
    output logic              cw_en,
    output logic [CR_AW-1:0]  cw_addr,
    output logic [2:0]        cw_val,
    output logic              done,
    output logic [VL_W-1:0]   vl_out
);
    logic             load;
    logic             adv;
    logic             fail;
    test_sel_e        sel_q;
    logic             pol_q;
    logic [IMM_W-1:0] imm_q;
    cond_t            cond;
    cond_t            cw_val_s;
    logic [CR_AW-1:0] dst_addr;

    ddff_index #(.AW(REG_AW)) u_src (
        .clk(clk), .rst(rst), .load(load), .base(src_base),
        .vec(src_vec), .adv(adv), .addr(rd_addr)
    );

    ddff_index #(.AW(CR_AW)) u_dst (
        .clk(clk), .rst(rst), .load(load), .base(dst_base),
        .vec(dst_vec), .adv(adv), .addr(dst_addr)
    );

    ddff_cmp #(.XLEN(XLEN)) u_cmp (
        .opnd(rd_data), .imm(imm_q), .cond(cond)
    );

    ddff_test u_test (
        .cond(cond), .sel(sel_q), .pol(pol_q), .fail(fail)
    );

    ddff_ctrl #(.VL_W(VL_W), .CR_AW(CR_AW)) u_ctrl (
        .clk(clk), .rst(rst), .start(start), .vl_in(vl_in),
        .incl_mode(incl_mode), .test_sel(test_sel), .test_pol(test_pol),
        .imm(imm), .cond(cond), .fail(fail), .dst_addr(dst_addr),
        .busy(busy), .load(load), .adv(adv), .sel_q(sel_q), .pol_q(pol_q),
        .imm_q(imm_q), .cw_en(cw_en), .cw_addr(cw_addr), .cw_val(cw_val_s),
        .done(done), .vl_out(vl_out)
    );

    assign cw_val = cw_val_s;

    assert_cond_onehot_R2: assert property (@(posedge clk) disable iff (rst)
        cw_en |-> ($countones(cw_val) == 1));
endmodule

// File: tb/sim_ddff_cmp_unit.sv
`timescale 1ns/1ps
module sim_ddff_cmp_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [6:0]  src_base;
    logic        src_vec;
    logic [5:0]  dst_base;
    logic        dst_vec;
    logic [15:0] imm;
    logic [6:0]  vl_in;
    logic [1:0]  test_sel;
    logic        test_pol;
    logic        incl_mode;
    logic [6:0]  rd_addr;
    logic [63:0] rd_data;
    logic        busy, cw_en, done;
    logic [5:0]  cw_addr;
    logic [2:0]  cw_val;
    logic [6:0]  vl_out;

    always #2.5 clk = ~clk;

    logic [63:0] regs [128];
    assign rd_data = regs[rd_addr];

    ddff_cmp_unit u0 (
        .clk(clk), .rst(rst), .start(start), .src_base(src_base),
        .src_vec(src_vec), .dst_base(dst_base), .dst_vec(dst_vec),
        .imm(imm), .vl_in(vl_in), .test_sel(test_sel), .test_pol(test_pol),
        .incl_mode(incl_mode), .rd_addr(rd_addr), .rd_data(rd_data),
        .busy(busy), .cw_en(cw_en), .cw_addr(cw_addr), .cw_val(cw_val),
        .done(done), .vl_out(vl_out)
    );

    typedef struct packed {
        logic [6:0]  sb;
        logic        sv;
        logic [5:0]  db;
        logic        dv;
        logic [15:0] im;
        logic [6:0]  vl;
        logic [1:0]  sel;
        logic        pol;
        logic        incl;
    } case_t;

    localparam int NCASE = 11;
    localparam case_t CASES [NCASE] = '{
        '{7'd30,  1'b1, 6'd0,  1'b1, 16'h0000, 7'd20, 2'd0, 1'b1, 1'b1},
        '{7'd30,  1'b1, 6'd0,  1'b1, 16'h0000, 7'd20, 2'd0, 1'b1, 1'b0},
        '{7'd0,   1'b1, 6'd60, 1'b1, 16'h0000, 7'd16, 2'd3, 1'b0, 1'b1},
        '{7'd45,  1'b0, 6'd10, 1'b1, 16'h0005, 7'd8,  2'd2, 1'b1, 1'b1},
        '{7'd30,  1'b1, 6'd7,  1'b0, 16'hFFFD, 7'd12, 2'd1, 1'b0, 1'b1},
        '{7'd50,  1'b1, 6'd0,  1'b1, 16'h0000, 7'd5,  2'd0, 1'b1, 1'b0},
        '{7'd0,   1'b1, 6'd0,  1'b1, 16'h0000, 7'd0,  2'd0, 1'b1, 1'b1},
        '{7'd30,  1'b1, 6'd20, 1'b1, 16'h0000, 7'd11, 2'd0, 1'b1, 1'b0},
        '{7'd30,  1'b1, 6'd20, 1'b1, 16'h0000, 7'd11, 2'd0, 1'b1, 1'b1},
        '{7'd126, 1'b1, 6'd3,  1'b1, 16'h8000, 7'd4,  2'd1, 1'b1, 1'b1},
        '{7'd126, 1'b1, 6'd3,  1'b1, 16'h8000, 7'd4,  2'd3, 1'b0, 1'b0}
    };
    string case_req [NCASE] = '{"R6", "R7", "R8", "R3", "R5", "R10",
                                "R9", "R7", "R6", "R2", "R3"};

    int errs   = 0;
    int checks = 0;

    task automatic chk(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [2:0] cond3(logic [63:0] v, logic [15:0] im);
        logic signed [63:0] a, b;
        a = v;
        b = {{48{im[15]}}, im};
        return {a < b, a > b, a == b};
    endfunction

    logic [5:0] e_addr [64];
    logic [2:0] e_val  [64];
    int e_n, e_vl, e_proc;

    task automatic model(case_t c);
        e_n = 0; e_vl = int'(c.vl); e_proc = int'(c.vl);
        for (int i = 0; i < int'(c.vl); i++) begin
            logic [6:0] s;
            logic [5:0] d;
            logic [2:0] cv;
            logic f;
            s  = 7'(int'(c.sb) + (c.sv ? i : 0));
            d  = 6'(int'(c.db) + (c.dv ? i : 0));
            cv = cond3(regs[s], c.im);
            case (c.sel)
                2'd0:    f = (cv[2] != c.pol);
                2'd1:    f = (cv[1] != c.pol);
                2'd2:    f = (cv[0] != c.pol);
                default: f = 1'b0;
            endcase
            if (!f || c.incl) begin
                e_addr[e_n] = d; e_val[e_n] = cv; e_n++;
            end
            if (f) begin
                e_vl = c.incl ? i + 1 : i;
                e_proc = i + 1;
                return;
            end
        end
    endtask

    task automatic run_case(case_t c, string req, bit poke);
        int n, a_n, done_n;
        logic [5:0] a_addr [64];
        logic [2:0] a_val  [64];
        int a_cyc [64];
        model(c);
        @(negedge clk);
        src_base = c.sb; src_vec = c.sv; dst_base = c.db; dst_vec = c.dv;
        imm = c.im; vl_in = c.vl; test_sel = c.sel; test_pol = c.pol;
        incl_mode = c.incl; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 1; a_n = 0; done_n = -1;
        if (c.vl != 0) chk("R11", "busy during run", busy, 1);
        while (n < 100) begin
            if (cw_en && a_n < 64) begin
                a_addr[a_n] = cw_addr; a_val[a_n] = cw_val; a_cyc[a_n] = n; a_n++;
            end
            if (done) begin done_n = n; break; end
            if (poke && n == 3) begin
                start = 1'b1; vl_in = 7'd0; src_base = 7'd99; incl_mode = ~c.incl;
            end else if (poke && n == 4) begin
                start = 1'b0;
            end
            @(negedge clk);
            n++;
        end
        start = 1'b0;
        chk(req, "write count", a_n, e_n);
        for (int k = 0; k < a_n && k < e_n; k++) begin
            chk("R4", "write address", a_addr[k], e_addr[k]);
            chk("R2", "condition value", a_val[k], e_val[k]);
            chk("R12", "write cycle", a_cyc[k], k + 2);
        end
        chk(req, "vl_out", vl_out, e_vl);
        chk("R12", "done cycle", done_n, (c.vl == 0) ? 1 : e_proc + 1);
        @(negedge clk);
        chk("R11", "done is one pulse", done, 0);
        chk("R11", "idle after done", busy, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        for (int k = 0; k < 128; k++)
            regs[k] = (k < 120) ? 64'(k - 40)
                    : (k % 2 == 0) ? 64'h7FFF_FFFF_FFFF_FFF0 : 64'h8000_0000_0000_0010;
        rst = 1'b1; start = 1'b0; src_base = '0; src_vec = 1'b0; dst_base = '0;
        dst_vec = 1'b0; imm = '0; vl_in = '0; test_sel = '0; test_pol = 1'b0;
        incl_mode = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", "busy in reset", busy, 0);
        chk("R1", "done in reset", done, 0);
        chk("R1", "cw_en in reset", cw_en, 0);
        chk("R1", "vl_out in reset", vl_out, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "busy after reset", busy, 0);

        for (int t = 0; t < NCASE; t++) run_case(CASES[t], case_req[t], 1'b0);

        // R11: a start pulse during a run must not disturb it
        run_case(CASES[0], "R11", 1'b1);

        // R1: reset in the middle of a run abandons it
        @(negedge clk);
        src_base = 7'd0; src_vec = 1'b1; dst_base = 6'd0; dst_vec = 1'b1;
        vl_in = 7'd30; test_sel = 2'd3; incl_mode = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R1", "busy after mid-run reset", busy, 0);
        chk("R1", "cw_en after mid-run reset", cw_en, 0);
        chk("R1", "vl_out after mid-run reset", vl_out, 0);
        rst = 1'b0;
        run_case(CASES[3], "R3", 1'b0);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule